// File: doc/BRIEF.md
# Alarm Comparator with Repeat Masks

This block holds a four-field alarm (seconds, minutes, hours, day of month) and compares it against the BCD time and date that an external clock/calendar counter presents. The comparison runs only when the once-per-second `tick` strobe arrives. The interrupt output `alarm_pulse` goes high for exactly one cycle when the alarm matches. Bit 7 of each alarm byte is a "don't care" flag for that field. The pattern of these flags sets how often the alarm repeats: once a month, once a day, once an hour, once a minute or on every second.

Software loads the alarm through a plain byte write port. A write to any field is checked for a legal BCD range. An out-of-range byte is dropped and the old contents stay in place. Any field can be read back through a separate combinational select. The port has no valid/ready handshake because a write completes in a single cycle. For the same reason the time inputs are sampled levels and take no back-pressure.

Top module: `alarm_repeat_match`

## Requirements
- R1: After reset all four alarm bytes read 0x00 and `alarm_pulse` is low.
- R2: Field selects are 0 = seconds, 1 = minutes, 2 = hours, 3 = date. `rd_data` returns the selected field's last accepted byte, bit 7 included, in the same cycle the select is applied.
- R3: A seconds or minutes write is accepted only when bits 6:0 decode to a value of 59 or less. The decoded value is (bits 6:4)×10 + (bits 3:0). A rejected write leaves all fields unchanged.
- R4: An hours write is accepted only when (bits 5:4)×10 + (bits 3:0) is 23 or less. Otherwise nothing changes.
- R5: A date write is accepted only when bits 4:0 are not all zero. Otherwise nothing changes.
- R6: `alarm_pulse` is high for exactly the one cycle after a cycle with `tick` high and a match. It is never high otherwise, so each tick gives at most one pulse.
- R7: With no mask bits set, a match needs equality of seconds and minutes (bits 6:0) and of hours and date (bits 5:0). The alarm then repeats monthly.
- R8: With only the date mask set, a match needs seconds, minutes and hours to be equal. The date is ignored, so the alarm repeats daily.
- R9: With the date and hours masks set and the others clear, a match needs seconds and minutes to be equal. The alarm repeats hourly.
- R10: With the date, hours and minutes masks set and the seconds mask clear, a match needs only the seconds to be equal. The alarm repeats every minute.
- R11: Any other mask pattern produces a pulse on every tick, whatever the time inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Alarm field write strobe |
| wr_sel | input | 2 | Field written (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Byte written, bit 7 is the field mask |
| rd_sel | input | 2 | Field read back |
| rd_data | output | 8 | Selected alarm byte |
| alarm_pulse | output | 1 | One-cycle alarm interrupt |

## Verification
The assertions assume that `tick` is a single-cycle strobe and never stays high on two consecutive cycles. The one-pulse-per-tick property depends on that, and the checker tests the assumption directly. The bench raises `tick` for one cycle and then holds it low for at least two cycles. It changes the time inputs only in cycles without a tick and drives `wr_en` low throughout reset. A test that issues a write and a tick in the same cycle is not included.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DW     = 8;
  localparam int FIELDS = 4;
  localparam int SEL_W  = $clog2(FIELDS);

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  localparam int MASK_BIT = DW - 1;

  typedef logic [DW-1:0] bcd_t;

  // two-digit decode: tens * 10 + units (max 165, fits 8 bits)
  function automatic logic [7:0] bcd_value(input bcd_t v);
    return ({4'b0, v[7:4]} * 8'd10) + {4'b0, v[3:0]};
  endfunction

  function automatic logic write_ok(input logic [SEL_W-1:0] idx, input bcd_t d);
    logic ok;
    case (int'(idx))
      F_SEC, F_MIN: ok = (bcd_value(d & 8'h7F) <= 8'd59);
      F_HOUR:       ok = (bcd_value(d & 8'h3F) <= 8'd23);
      default:      ok = ((d & 8'h1F) != 8'h00);
    endcase
    return ok;
  endfunction

  function automatic bcd_t cmp_mask(input int idx);
    return (idx == F_SEC || idx == F_MIN) ? 8'h7F : 8'h3F;
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  bcd_t                        wr_data,
  output logic [FIELDS-1:0][DW-1:0]   regs
);
  logic legal;
  assign legal = write_ok(wr_sel, wr_data);

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    logic hit;
    assign hit = wr_en && legal && (wr_sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[i] <= '0;
      else if (hit) regs[i] <= wr_data;
    end
  end
endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode
  import alarm_pkg::*;
(
  input  logic [FIELDS-1:0] masks,   // index = field
  output logic [FIELDS-1:0] use_fld  // field takes part in the compare
);
  always_comb begin
    case (masks)
      4'b0000: use_fld = 4'b1111;  // monthly
      4'b1000: use_fld = 4'b0111;  // daily
      4'b1100: use_fld = 4'b0011;  // hourly
      4'b1110: use_fld = 4'b0001;  // every minute
      default: use_fld = 4'b0000;  // every second
    endcase
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import alarm_pkg::*;
(
  input  logic [FIELDS-1:0][DW-1:0] regs,
  input  logic [FIELDS-1:0][DW-1:0] now,
  input  logic [FIELDS-1:0]         use_fld,
  output logic                      match
);
  logic [FIELDS-1:0] ok;
  for (genvar i = 0; i < FIELDS; i++) begin : g_cmp
    assign ok[i] = !use_fld[i] ||
                   ((regs[i] & cmp_mask(i)) == (now[i] & cmp_mask(i)));
  end
  assign match = &ok;
endmodule

// File: rtl/alarm_repeat_match.sv
module alarm_repeat_match
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DW-1:0]    now_sec,
  input  logic [DW-1:0]    now_min,
  input  logic [DW-1:0]    now_hour,
  input  logic [DW-1:0]    now_date,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             alarm_pulse
);
  logic [FIELDS-1:0][DW-1:0] alarm_regs;
  logic [FIELDS-1:0][DW-1:0] now_all;
  logic [FIELDS-1:0]         masks;
  logic [FIELDS-1:0]         use_fld;
  logic                      match;

  assign now_all = {now_date, now_hour, now_min, now_sec};

  alarm_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .regs(alarm_regs)
  );

  for (genvar i = 0; i < FIELDS; i++) begin : g_mask
    assign masks[i] = alarm_regs[i][MASK_BIT];
  end

  alarm_rate_decode u_rate (.masks(masks), .use_fld(use_fld));

  alarm_compare u_cmp (
    .regs(alarm_regs), .now(now_all), .use_fld(use_fld), .match(match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_pulse <= 1'b0;
    else        alarm_pulse <= tick && match;
  end

  assign rd_data = alarm_regs[rd_sel];
endmodule

// File: rtl/alarm_repeat_match_chk.sv
module alarm_repeat_match_chk
  import alarm_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic                      wr_en,
  input logic [SEL_W-1:0]          wr_sel,
  input logic [DW-1:0]             wr_data,
  input logic [FIELDS-1:0][DW-1:0] alarm_regs,
  input logic                      alarm_pulse
);
  // R6
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(tick));

  // R3 R4 R5
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !write_ok(wr_sel, wr_data)) |=> $stable(alarm_regs));

  // R2
  accept_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && write_ok(wr_sel, wr_data)) |=>
      (alarm_regs[$past(wr_sel)] == $past(wr_data)));

  // R11
  sec_mask_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && alarm_regs[F_SEC][MASK_BIT]) |=> alarm_pulse);
endmodule

bind alarm_repeat_match alarm_repeat_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .alarm_regs(alarm_regs), .alarm_pulse(alarm_pulse)
);

// File: tb/alarm_repeat_match_bench.sv
module alarm_repeat_match_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_date = 0;
  logic       wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rd_sel = 0;
  logic [7:0] rd_data;
  logic       alarm_pulse;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  alarm_repeat_match u_alarm_repeat_match (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .alarm_pulse(alarm_pulse)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int dec2(input int tens, input int units);
    return tens * 10 + units;
  endfunction

  function automatic logic legal(input int f, input logic [7:0] d);
    if (f <= 1) return dec2(int'(d[6:4]), int'(d[3:0])) <= 59;  // R3
    if (f == 2) return dec2(int'(d[5:4]), int'(d[3:0])) <= 23;  // R4
    return d[4:0] != 5'd0;                                      // R5
  endfunction

  task automatic wr(input int f, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = f[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (legal(f, d)) model[f] = d;
  endtask

  task automatic rd_chk(input int f, input string req);
    rd_sel = f[1:0];
    #1;
    check(rd_data == model[f], req, rd_data, model[f]);
  endtask

  // one tick with given time; expect pulse 'exp'
  task automatic do_tick(input logic [7:0] s, input logic [7:0] m,
                         input logic [7:0] h, input logic [7:0] d,
                         input logic exp, input string req);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = d;
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
    check(alarm_pulse == exp, req, alarm_pulse, exp);
    @(negedge clk);
    check(alarm_pulse == 1'b0, "R6", alarm_pulse, 0);
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int f = 0; f < 4; f++) rd_chk(f, "R1");
    check(alarm_pulse == 1'b0, "R1", alarm_pulse, 0);

    // R2 R3 R4 R5: exhaustive write sweep per field
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 256; v++) begin
        wr(f, v[7:0]);
        for (int g = 0; g < 4; g++)
          rd_chk(g, f <= 1 ? "R3" : (f == 2 ? "R4" : "R5"));
      end
    end

    // R7 R8 R9 R10 R11: every mask pattern x every equality pattern
    for (int mp = 0; mp < 16; mp++) begin
      wr(0, {mp[0], 7'h15});
      wr(1, {mp[1], 7'h30});
      wr(2, {mp[2], 7'h12});
      wr(3, {mp[3], 7'h07});
      for (int c = 0; c < 16; c++) begin
        logic [3:0] use_f;
        logic       exp;
        string      req;
        case (mp)
          0:  begin use_f = 4'b1111; req = "R7";  end
          8:  begin use_f = 4'b0111; req = "R8";  end
          12: begin use_f = 4'b0011; req = "R9";  end
          14: begin use_f = 4'b0001; req = "R10"; end
          default: begin use_f = 4'b0000; req = "R11"; end
        endcase
        exp = ((use_f & ~c[3:0]) == 4'b0000);
        do_tick(c[0] ? 8'h15 : 8'h16,
                c[1] ? 8'h30 : 8'h31,
                c[2] ? 8'h12 : 8'h13,
                c[3] ? 8'h07 : 8'h08, exp, req);
      end
    end

    // R6: no tick, matching time, no pulse
    wr(0, 8'h15); wr(1, 8'h30); wr(2, 8'h12); wr(3, 8'h07);
    now_sec = 8'h15; now_min = 8'h30; now_hour = 8'h12; now_date = 8'h07;
    repeat (3) begin
      @(negedge clk);
      check(alarm_pulse == 1'b0, "R6", alarm_pulse, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule